// File: doc/BRIEF.md
# Step-Down Regulator Fault Sequencer

This block sits between the digitized comparator outputs of a step-down switching regulator and its gate drive and soft-start logic. It turns six raw fault flags into gate-enable permissions for the high-side and low-side switches, a discharge-resistor enable, a one-cycle restart request to the soft-start block, and a one-hot code that names the fault being handled. All filtering and waiting is counted either in system clock cycles or in switching periods, which arrive as a one-cycle strobe.

Each fault class has its own treatment. Overvoltage is blanked for a set number of clock cycles. The block then crowbars the output through the low-side switch and returns to regulation once the output falls below the recovery level. This return has no restart. Undervoltage, or an overcurrent that repeats over several consecutive switching periods, turns both switches off. The discharge resistor is then enabled for three soft-start periods, after which a restart is requested. A single overcurrent flag only cuts the current high-side pulse. Over-temperature uses two thresholds, so the block restarts only after the die has cooled below the release level. A low supply overrides everything else, and reset clears every latched fault.

Top module: `buck_fault_seq`

## Requirements
- R1: While reset is held, or whenever `vsup_low` is 1, both switch permissions are 0 and `fault_code` is 5'b10000. Supply low overrides every other fault.
- R2: Overvoltage latches only after `vout_over_hi` is sampled high on `OV_BLANK_CYC` consecutive clock edges. A shorter run has no effect.
- R3: During an overvoltage fault (`fault_code` 5'b00001):
  - `hs_allow` is 0, and `ls_allow` and `ls_crowbar` are 1.
  - The fault holds while `vout_over_rec` is 1.
  - Once `vout_over_rec` is 0, regulation resumes on the next edge without a restart request.
- R4: Undervoltage trips on the (`UV_TICKS`+1)-th switching strobe that samples `vout_under` high with no gap. A single clock cycle of `vout_under` low clears the count.
- R5: While `hs_peak_oc` is 1, `hs_allow` is 0 in that same cycle. One such event causes no state change.
- R6: Overcurrent trips when `hs_peak_oc` was seen in each of `OC_REPEAT` consecutive switching periods. A period without it restarts the count.
- R7: An undervoltage or overcurrent trip starts a hiccup wait:
  - Both permissions are 0 and `dschg_en` is 1.
  - The wait lasts exactly 3×`SS_CYC` clock cycles.
  - After the wait, regulation resumes.
- R8: When `temp_over` is 1, both switches turn off and `fault_code` is 5'b01000. The fault clears only when `temp_below_rel` is 1 and `temp_over` is 0.
- R9: `fault_code` is one-hot or zero:
  - bit0 overvoltage
  - bit1 undervoltage
  - bit2 overcurrent
  - bit3 over-temperature
  - bit4 supply low
  - It is zero in normal regulation, where `hs_allow` and `ls_allow` are 1.
- R10: Priority is supply low, then over-temperature, then overvoltage, then undervoltage, then overcurrent. Over-temperature preempts a running hiccup wait.
- R11: `ss_restart` is a one-cycle pulse. It is raised on the edge where the block returns to regulation from supply-low, over-temperature or hiccup, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_tick | input | 1 | One-cycle strobe per switching period |
| vout_over_hi | input | 1 | Output above overvoltage trip level |
| vout_over_rec | input | 1 | Output above overvoltage recovery level |
| vout_under | input | 1 | Output below undervoltage level |
| hs_peak_oc | input | 1 | High-side peak current above limit |
| temp_over | input | 1 | Die above shutdown temperature |
| temp_below_rel | input | 1 | Die below release temperature |
| vsup_low | input | 1 | Supply below lockout level |
| hs_allow | output | 1 | High-side switch may turn on |
| ls_allow | output | 1 | Low-side switch may turn on |
| ls_crowbar | output | 1 | Low-side switch forced on |
| dschg_en | output | 1 | Output discharge resistor enable |
| ss_restart | output | 1 | Restart request pulse to soft-start |
| fault_code | output | 5 | One-hot active fault |

## Verification
Two cases are provoked where two protection functions land on the same clock edge.

- **Supply low and over-temperature together.** Both flags rise on one edge while the block is regulating. The result is judged by `fault_code` reading supply-low alone, with both switches off.
- **Over-temperature during a hiccup wait.** Over-temperature arrives part way through the discharge wait that follows an undervoltage trip. The result is judged by:
  - the code switching to over-temperature on the next edge;
  - the discharge enable dropping;
  - exactly one restart pulse, issued only once the cool flag returns.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0,
    ST_RUN  = 3'd1,
    ST_OVP  = 3'd2,
    ST_HIC  = 3'd3,
    ST_OTP  = 3'd4
  } seq_state_e;

  typedef enum logic {
    CAUSE_UV = 1'b0,
    CAUSE_OC = 1'b1
  } hic_cause_e;

  localparam int FC_W   = 5;
  localparam int FC_OV  = 0;
  localparam int FC_UV  = 1;
  localparam int FC_OC  = 2;
  localparam int FC_OT  = 3;
  localparam int FC_SUP = 4;

endpackage

// File: rtl/bfs_persist_filter.sv
// Counts qualifying steps while a level stays high; any low cycle or a
// disarmed filter clears the count. Trip fires on the LIMIT-th step.
module bfs_persist_filter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic level,
  input  logic step,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign trip = arm && level && step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!arm || !level) begin
      cnt <= '0;
    end else if (step && (cnt != LAST)) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/bfs_oc_repeat.sv
// Tracks whether a peak overcurrent occurred inside each switching period
// and trips after REPEAT consecutive periods that each saw one.
module bfs_oc_repeat #(
  parameter int REPEAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sw_tick,
  input  logic oc_flag,
  output logic trip
);
  localparam int CW = $clog2(REPEAT + 1);
  localparam logic [CW-1:0] LAST = CW'(REPEAT - 1);

  logic          seen;
  logic [CW-1:0] run_cnt;
  logic          period_hit;

  assign period_hit = seen || oc_flag;
  assign trip = arm && sw_tick && period_hit && (run_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      run_cnt <= '0;
    end else if (!arm) begin
      seen    <= 1'b0;
      run_cnt <= '0;
    end else if (sw_tick) begin
      seen <= 1'b0;
      if (!period_hit) begin
        run_cnt <= '0;
      end else if (run_cnt != LAST) begin
        run_cnt <= run_cnt + CW'(1);
      end
    end else if (oc_flag) begin
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/bfs_hiccup_timer.sv
// Free count while running; done on the LEN-th cycle of a run.
module bfs_hiccup_timer #(
  parameter int LEN = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || done) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
  import buck_fault_pkg::*;
#(
  parameter int OV_BLANK_CYC = 75,
  parameter int UV_TICKS     = 4,
  parameter int OC_REPEAT    = 4,
  parameter int SS_CYC       = 40000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_tick,
  input  logic            vout_over_hi,
  input  logic            vout_over_rec,
  input  logic            vout_under,
  input  logic            hs_peak_oc,
  input  logic            temp_over,
  input  logic            temp_below_rel,
  input  logic            vsup_low,
  output logic            hs_allow,
  output logic            ls_allow,
  output logic            ls_crowbar,
  output logic            dschg_en,
  output logic            ss_restart,
  output logic [FC_W-1:0] fault_code
);
  localparam int UV_LIMIT = UV_TICKS + 1;
  localparam int HIC_LEN  = 3 * SS_CYC;

  seq_state_e state, state_nxt;
  hic_cause_e cause, cause_nxt;
  logic       armed;
  logic       ov_trip, uv_trip, oc_trip, hic_done;
  logic       restart_nxt;

  assign armed = (state == ST_RUN);

  bfs_persist_filter #(.LIMIT(OV_BLANK_CYC)) u_ov_filt (
    .clk(clk), .rst_n(rst_n), .arm(armed),
    .level(vout_over_hi), .step(1'b1), .trip(ov_trip)
  );

  bfs_persist_filter #(.LIMIT(UV_LIMIT)) u_uv_filt (
    .clk(clk), .rst_n(rst_n), .arm(armed),
    .level(vout_under), .step(sw_tick), .trip(uv_trip)
  );

  bfs_oc_repeat #(.REPEAT(OC_REPEAT)) u_oc_rep (
    .clk(clk), .rst_n(rst_n), .arm(armed),
    .sw_tick(sw_tick), .oc_flag(hs_peak_oc), .trip(oc_trip)
  );

  bfs_hiccup_timer #(.LEN(HIC_LEN)) u_hic_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == ST_HIC), .done(hic_done)
  );

  // Next state with fixed fault priority: supply, temperature, then the
  // per-state handling (OV before UV before OC while regulating).
  always_comb begin
    state_nxt = state;
    cause_nxt = cause;
    if (vsup_low) begin
      state_nxt = ST_LOCK;
    end else if (temp_over && (state != ST_OTP)) begin
      state_nxt = ST_OTP;
    end else begin
      case (state)
        ST_LOCK: state_nxt = ST_RUN;
        ST_RUN: begin
          if (ov_trip) begin
            state_nxt = ST_OVP;
          end else if (uv_trip) begin
            state_nxt = ST_HIC;
            cause_nxt = CAUSE_UV;
          end else if (oc_trip) begin
            state_nxt = ST_HIC;
            cause_nxt = CAUSE_OC;
          end
        end
        ST_OVP:  if (!vout_over_rec) state_nxt = ST_RUN;
        ST_HIC:  if (hic_done) state_nxt = ST_RUN;
        ST_OTP:  if (temp_below_rel && !temp_over) state_nxt = ST_RUN;
        default: state_nxt = ST_LOCK;
      endcase
    end
  end

  assign restart_nxt = (state_nxt == ST_RUN) &&
                       (state == ST_LOCK || state == ST_HIC || state == ST_OTP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_LOCK;
      cause      <= CAUSE_UV;
      ss_restart <= 1'b0;
    end else begin
      state      <= state_nxt;
      cause      <= cause_nxt;
      ss_restart <= restart_nxt;
    end
  end

  // Output decode from the sequencer state.
  always_comb begin
    hs_allow   = 1'b0;
    ls_allow   = 1'b0;
    ls_crowbar = 1'b0;
    dschg_en   = 1'b0;
    fault_code = '0;
    case (state)
      ST_RUN: begin
        hs_allow = !hs_peak_oc;
        ls_allow = 1'b1;
      end
      ST_OVP: begin
        ls_allow          = 1'b1;
        ls_crowbar        = 1'b1;
        fault_code[FC_OV] = 1'b1;
      end
      ST_HIC: begin
        dschg_en = 1'b1;
        if (cause == CAUSE_UV) fault_code[FC_UV] = 1'b1;
        else                   fault_code[FC_OC] = 1'b1;
      end
      ST_OTP:  fault_code[FC_OT]  = 1'b1;
      default: fault_code[FC_SUP] = 1'b1;
    endcase
  end
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vout_over_rec,
  input logic       hs_peak_oc,
  input logic       temp_over,
  input logic       temp_below_rel,
  input logic       vsup_low,
  input logic       hs_allow,
  input logic       ls_allow,
  input logic       ls_crowbar,
  input logic       dschg_en,
  input logic       ss_restart,
  input logic [4:0] fault_code
);
  assert_code_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_code));

  assert_supply_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vsup_low |=> (fault_code == 5'b10000) && !hs_allow && !ls_allow);

  assert_crowbar_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ls_crowbar |-> (!hs_allow && ls_allow && fault_code == 5'b00001));

  assert_ov_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code[0] && vout_over_rec && !vsup_low && !temp_over) |=> fault_code[0]);

  assert_no_restart_after_ov_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> ($past(fault_code) != 5'b00001));

  assert_peak_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_peak_oc |-> !hs_allow);

  assert_discharge_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dschg_en |-> (!hs_allow && !ls_allow));

  assert_ot_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_over && !vsup_low) |=> (fault_code == 5'b01000));

  assert_ot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code[3] && !temp_below_rel && !vsup_low) |=> fault_code[3]);

  assert_restart_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
endmodule

bind buck_fault_seq bfs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vout_over_rec(vout_over_rec),
  .hs_peak_oc(hs_peak_oc), .temp_over(temp_over),
  .temp_below_rel(temp_below_rel), .vsup_low(vsup_low),
  .hs_allow(hs_allow), .ls_allow(ls_allow), .ls_crowbar(ls_crowbar),
  .dschg_en(dschg_en), .ss_restart(ss_restart), .fault_code(fault_code)
);

// File: tb/buck_fault_seq_tb.sv
module buck_fault_seq_tb;
  localparam int OVB = 8;
  localparam int UVT = 4;
  localparam int OCR = 4;
  localparam int SS  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tick = 1'b0;
  logic ovh = 1'b0, ovr = 1'b0, uv = 1'b0, oc = 1'b0;
  logic th = 1'b0, tcool = 1'b1, vsl = 1'b0;
  logic hs_allow, ls_allow, ls_crowbar, dschg_en, ss_restart;
  logic [4:0] fault_code;
  int tests = 0, fails = 0;
  int div = 0;
  int rs_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div     <= (div == 4) ? 0 : div + 1;
    sw_tick <= (div == 3);
    if (ss_restart) rs_cnt <= rs_cnt + 1;
  end

  buck_fault_seq #(.OV_BLANK_CYC(OVB), .UV_TICKS(UVT), .OC_REPEAT(OCR), .SS_CYC(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick),
    .vout_over_hi(ovh), .vout_over_rec(ovr), .vout_under(uv),
    .hs_peak_oc(oc), .temp_over(th), .temp_below_rel(tcool), .vsup_low(vsl),
    .hs_allow(hs_allow), .ls_allow(ls_allow), .ls_crowbar(ls_crowbar),
    .dschg_en(dschg_en), .ss_restart(ss_restart), .fault_code(fault_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (sw_tick) k++;
    end
  endtask

  // {ovh,ovr,uv,oc,th,tcool,vsl}, hold cycles, fault code, {hs,ls,crowbar,dschg}
  localparam logic [23:0] VEC [16] = '{
    {7'b0000010, 8'd3,  5'b00000, 4'b1100},
    {7'b1100010, 8'd20, 5'b00001, 4'b0110},
    {7'b0100010, 8'd5,  5'b00001, 4'b0110},
    {7'b0000010, 8'd2,  5'b00000, 4'b1100},
    {7'b0010010, 8'd40, 5'b00010, 4'b0001},
    {7'b0000010, 8'd20, 5'b00010, 4'b0001},
    {7'b0000010, 8'd40, 5'b00000, 4'b1100},
    {7'b0001010, 8'd60, 5'b00100, 4'b0001},
    {7'b0000010, 8'd40, 5'b00000, 4'b1100},
    {7'b0000100, 8'd3,  5'b01000, 4'b0000},
    {7'b0000000, 8'd5,  5'b01000, 4'b0000},
    {7'b0000010, 8'd2,  5'b00000, 4'b1100},
    {7'b0000101, 8'd3,  5'b10000, 4'b0000},
    {7'b0000010, 8'd2,  5'b00000, 4'b1100},
    {7'b0001010, 8'd1,  5'b00000, 4'b0100},
    {7'b0000010, 8'd1,  5'b00000, 4'b1100}
  };

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int len;
    int rs0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset code", fault_code, 5'b10000);
    chk("R1 reset switches", {hs_allow, ls_allow}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 restart after lock", ss_restart, 1);
    chk("R9 run code zero", fault_code, 0);
    @(negedge clk);
    chk("R11 single pulse", ss_restart, 0);

    for (int i = 0; i < 16; i++) begin
      {ovh, ovr, uv, oc, th, tcool, vsl} = VEC[i][23:17];
      repeat (int'(VEC[i][16:9])) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R9/R10 row %0d code", i), fault_code, int'(VEC[i][8:4]));
      chk($sformatf("R3/R5/R7/R8 row %0d outputs", i),
          {hs_allow, ls_allow, ls_crowbar, dschg_en}, int'(VEC[i][3:0]));
    end

    // R2 blanking boundary, R3 recovery without restart
    rs0 = rs_cnt;
    ovh = 1'b1; ovr = 1'b1;
    repeat (OVB - 1) @(posedge clk);
    @(negedge clk) ovh = 1'b0;
    chk("R2 short overvoltage ignored", fault_code, 0);
    @(negedge clk) ovh = 1'b1;
    repeat (OVB) @(posedge clk);
    @(negedge clk);
    chk("R2 overvoltage latched", fault_code, 5'b00001);
    ovh = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 holds above recovery", fault_code, 5'b00001);
    ovr = 1'b0;
    @(negedge clk);
    chk("R3 direct recovery", fault_code, 0);
    chk("R3 no restart pulse", ss_restart, 0);
    repeat (3) @(negedge clk);
    chk("R3 no restart counted", rs_cnt - rs0, 0);

    // R4 filter cleared by a one-cycle gap
    uv = 1'b1;
    wait_ticks(UVT);
    @(negedge clk) uv = 1'b0;
    @(negedge clk) uv = 1'b1;
    wait_ticks(UVT);
    @(negedge clk);
    chk("R4 gap restarts count", fault_code, 0);
    wait_ticks(1);
    @(negedge clk);
    chk("R4 undervoltage trip", fault_code, 5'b00010);
    uv = 1'b0;
    len = 0;
    while (dschg_en && len < 1000) begin len++; @(negedge clk); end

    // R6 consecutive periods, R7 exact hiccup length
    @(negedge clk) oc = 1'b1;
    wait_ticks(OCR - 1);
    @(negedge clk) oc = 1'b0;
    wait_ticks(2);
    @(negedge clk);
    chk("R6 broken run ignored", fault_code, 0);
    oc = 1'b1;
    wait_ticks(OCR - 1);
    @(negedge clk);
    chk("R6 below repeat count", fault_code, 0);
    wait_ticks(1);
    @(negedge clk);
    chk("R6 repeated overcurrent", fault_code, 5'b00100);
    oc = 1'b0;
    len = 0;
    while (dschg_en && len < 1000) begin len++; @(negedge clk); end
    chk("R7 hiccup length", len, 3 * SS);
    chk("R7 restart after hiccup", ss_restart, 1);
    chk("R7 back to regulation", {hs_allow, ls_allow}, 2'b11);

    // R10 over-temperature preempts hiccup; R8 hysteresis; R11 restart
    @(negedge clk) uv = 1'b1;
    len = 0;
    while (!dschg_en && len < 100) begin len++; @(negedge clk); end
    chk("R4 hiccup from undervoltage", fault_code, 5'b00010);
    uv = 1'b0; th = 1'b1; tcool = 1'b0;
    @(negedge clk);
    chk("R10 temperature preempts hiccup", fault_code, 5'b01000);
    chk("R10 discharge dropped", dschg_en, 0);
    th = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 hysteresis hold", fault_code, 5'b01000);
    tcool = 1'b1;
    @(negedge clk);
    chk("R8 released", fault_code, 0);
    chk("R11 restart after temperature", ss_restart, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule